// File: doc/BRIEF.md
# Selectable-Ratio Reference Divider with Switchable Output

This block takes the reference clock of a frequency synthesiser, which comes from a crystal oscillator or from an external source, and divides it down to the comparison frequency used by the phase detector. A 4-bit code picks one of sixteen division ratios. The ratio table is not a plain power-of-two ladder. Half of the codes give powers of two from 2 to 256. The other half give 24, 5 and the doublings of 5 up to 320. The comparison clock appears in two forms. One is a single-cycle pulse that marks each terminal count. The other is a level that the phase comparator can use by its edges.

A second path drives an output pin for a companion synthesiser. That pin can carry the undivided reference clock or the comparison level, or it can be released to high impedance. The enable and select bits both come up set out of reset, so by default the pin carries the comparison frequency. The ratio code is taken up only at a terminal count, so a retune never cuts a comparison period short.

Top module: `refdiv_top`

## Requirements
- R1: Code values 0 to 7 give a division ratio of 2 to the power (code+1): 2, 4, 8, 16, 32, 64, 128, 256.
- R2: Code 8 gives ratio 24. Codes 9 to 15 give 5, 10, 20, 40, 80, 160, 320: ratio = 5 * 2^(code-9).
- R3: Reset is synchronous and active low, and it takes the code presented during reset. The first `compPulse` is high for one cycle after exactly N rising edges following reset release. Later pulses repeat every N cycles and are one cycle wide.
- R4: For an even ratio N, the comparison level is high for the last N/2 cycles of each period and falls right after the pulse cycle. For an odd ratio, the level equals the pulse.
- R5: A new code is adopted at the next terminal count. The period in progress keeps its old length.
- R6: When `refOutEn` was low at the previous rising edge, `refOutOe` is low and `refOut` is 0, whatever `refOutSel` is.
- R7: When the enable and select bits registered at the last edge are 1 and 0, `refOut` follows the reference clock in both clock phases.
- R8: When the enable and select bits registered at the last edge are both 1, `refOut` equals the comparison level.
- R9: During and right after reset, `refOutOe` is 1, the comparison selection is active, and `compPulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock to be divided |
| rstN | input | 1 | Synchronous active-low reset |
| ratioCode | input | 4 | Division ratio code |
| refOutEn | input | 1 | Output pin enable, registered |
| refOutSel | input | 1 | Output source: 0 reference, 1 comparison, registered |
| compPulse | output | 1 | One-cycle pulse at each comparison period |
| refOut | output | 1 | Multiplexed reference/comparison output value |
| refOutOe | output | 1 | Output driver enable; low means high impedance |

## Verification
Two things can happen in the same cycle: a terminal count of the divider and a change of the ratio code. The change only counts if the new code is taken up exactly at that wrap. The bench changes the code early in a period and keeps it stable up to and past the terminal count. The scoreboard then expects the first pulse at the old ratio and every later pulse at the new spacing, so a code adopted a cycle early or late shows up as a misplaced pulse. Output-select changes are also made while the divider is running. The comparison level on the pin is then checked cycle by cycle against the count computed in the bench.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 9;

  typedef struct packed {
    logic clear;
    logic count;
  } divStrobe_t;

  function automatic logic [CNT_W-1:0] ratioOf(input logic [CODE_W-1:0] code);
    logic [2:0] low;
    low = code[2:0];
    if (!code[CODE_W-1])
      return CNT_W'(2) << low;
    else if (low == 3'd0)
      return CNT_W'(24);
    else
      return CNT_W'(5) << (low - 3'd1);
  endfunction
endpackage

// File: rtl/refdiv_dp.sv
module refdiv_dp
  import refdiv_pkg::*;
#(
  parameter int WIDTH = CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  output logic [WIDTH-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear)
      cnt <= '0;
    else if (strobe.count)
      cnt <= cnt + WIDTH'(1);
  end
endmodule

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter int CW    = CODE_W,
  parameter int WIDTH = CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CW-1:0]    ratioCode,
  input  logic [WIDTH-1:0] cnt,
  output divStrobe_t       strobe,
  output logic             compPulse,
  output logic             compLevel
);
  logic [CW-1:0]    activeCode;
  logic [WIDTH-1:0] ratio;
  logic [WIDTH-1:0] lastVal;
  logic [WIDTH-1:0] half;
  logic             isOdd;
  logic             terminal;

  always_comb begin
    ratio    = ratioOf(activeCode);
    lastVal  = ratio - WIDTH'(1);
    half     = ratio >> 1;
    isOdd    = ratio[0];
    terminal = (cnt == lastVal);
    strobe.clear = terminal;
    strobe.count = !terminal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCode <= ratioCode;
      compPulse  <= 1'b0;
      compLevel  <= 1'b0;
    end else begin
      compPulse <= terminal;
      compLevel <= isOdd ? terminal : (cnt >= half);
      if (terminal)
        activeCode <= ratioCode;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastVal);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    compPulse |=> !compPulse);

  // R4
  level_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(compLevel) |-> $past(compPulse));
endmodule

// File: rtl/refdiv_outsel.sv
module refdiv_outsel (
  input  logic clk,
  input  logic rstN,
  input  logic enIn,
  input  logic selIn,
  input  logic compLevel,
  output logic muxOut,
  output logic muxOutOe
);
  logic enReg;
  logic selReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= 1'b1;
      selReg <= 1'b1;
    end else begin
      enReg  <= enIn;
      selReg <= selIn;
    end
  end

  always_comb begin
    muxOutOe = enReg;
    if (!enReg)
      muxOut = 1'b0;
    else if (selReg)
      muxOut = compLevel;
    else
      muxOut = clk;
  end

  // R6
  disable_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> !muxOutOe);

  // R9
  reset_enable_chk: assert property (@(posedge clk)
    !rstN |=> muxOutOe);
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic              refOutEn,
  input  logic              refOutSel,
  output logic              compPulse,
  output logic              refOut,
  output logic              refOutOe
);
  divStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;
  logic             compLevel;

  refdiv_dp #(.WIDTH(CNT_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cnt    (cnt)
  );

  refdiv_ctrl #(.CW(CODE_W), .WIDTH(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ratioCode (ratioCode),
    .cnt       (cnt),
    .strobe    (strobe),
    .compPulse (compPulse),
    .compLevel (compLevel)
  );

  refdiv_outsel uOut (
    .clk       (clk),
    .rstN      (rstN),
    .enIn      (refOutEn),
    .selIn     (refOutSel),
    .compLevel (compLevel),
    .muxOut    (refOut),
    .muxOutOe  (refOutOe)
  );
endmodule

// File: tb/sim_refdiv_top.sv
module sim_refdiv_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] ratioCode = 4'd0;
  logic       refOutEn = 1'b1;
  logic       refOutSel = 1'b1;
  logic       compPulse;
  logic       refOut;
  logic       refOutOe;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit scoring = 1'b0;
  bit done = 1'b0;
  int expQ[$];
  string curTag = "R3";

  refdiv_top u0 (
    .clk       (clk),
    .rstN      (rstN),
    .ratioCode (ratioCode),
    .refOutEn  (refOutEn),
    .refOutSel (refOutSel),
    .compPulse (compPulse),
    .refOut    (refOut),
    .refOutOe  (refOutOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int ratioModel(input int code);
    if (code < 8) return 2 << code;
    if (code == 8) return 24;
    return 5 << (code - 9);
  endfunction

  // monitor: pops expected pulse cycles as pulses appear
  always @(negedge clk) begin
    if (scoring && rstN) begin
      if (compPulse) begin
        if (expQ.size() == 0) check({curTag, " unexpected pulse"}, cyc, -1);
        else check({curTag, " pulse cycle"}, cyc, expQ.pop_front());
      end else if (expQ.size() != 0 && cyc > expQ[0]) begin
        check({curTag, " missed pulse"}, cyc, expQ.pop_front());
      end
    end
  end

  task automatic doReset(input int code);
    @(negedge clk);
    rstN = 1'b0;
    ratioCode = 4'(code);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // driver: push expected pulse cycles for one ratio
  task automatic runRatio(input int code);
    int n;
    n = ratioModel(code);
    curTag = (code < 8) ? "R1/R3" : "R2/R3";
    doReset(code);
    for (int k = 1; k <= 3; k++) expQ.push_back(k * n);
    scoring = 1'b1;
    repeat (3 * n + 2) @(negedge clk);
    scoring = 1'b0;
    check({curTag, " queue drained"}, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic levelRun(input int code, input string tag);
    int n;
    n = ratioModel(code);
    doReset(code);
    for (int k = 1; k <= 2 * n; k++) begin
      int pre;
      @(negedge clk);
      pre = (k - 1) % n;
      if (n % 2 == 1) check({tag, " odd level"}, refOut, (pre == n - 1) ? 1 : 0);
      else            check({tag, " even level"}, refOut, (pre >= n / 2) ? 1 : 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    check("R9 oe in reset", refOutOe, 1);
    check("R9 pulse in reset", compPulse, 0);
    check("R9 level in reset", refOut, 0);

    // R1, R2, R3: every code through the scoreboard
    for (int c = 0; c < 16; c++) runRatio(c);

    // R4, R8: level shape on the output pin
    refOutEn = 1'b1;
    refOutSel = 1'b1;
    levelRun(2, "R4/R8");
    levelRun(9, "R4/R8");
    levelRun(8, "R4/R8");

    // R5: code change mid-period takes effect at next wrap
    curTag = "R5";
    doReset(2);
    expQ.push_back(8);
    expQ.push_back(12);
    expQ.push_back(16);
    expQ.push_back(20);
    scoring = 1'b1;
    repeat (3) @(negedge clk);
    ratioCode = 4'd1;
    repeat (20) @(negedge clk);
    scoring = 1'b0;
    check("R5 queue drained", expQ.size(), 0);
    expQ.delete();

    // R6: disabled output regardless of select
    doReset(3);
    refOutEn = 1'b0;
    refOutSel = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 oe low sel1", refOutOe, 0);
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #2;
      check("R6 value high phase", refOut, 0);
    end
    refOutSel = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 oe low sel0", refOutOe, 0);
    @(posedge clk); #2;
    check("R6 value sel0", refOut, 0);

    // R7: reference passthrough
    @(negedge clk);
    refOutEn = 1'b1;
    refOutSel = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 oe", refOutOe, 1);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      check("R7 high phase", refOut, 1);
      #5;
      check("R7 low phase", refOut, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule